// File: doc/BRIEF.md
# Segmented Inverse-CDF Amplitude Sampler with Noise

This block turns uniform random words into signed detector samples at a rate of one per clock. When the hit flag is set, the upper bits of a uniform word choose one of several small lookup memories, and the lower bits address an entry inside it. Together the memories hold a monotone inverse cumulative distribution, so a uniform word becomes an amplitude that follows the target energy distribution.

An approximately Gaussian noise term is added on every cycle, whether or not a hit is present. It is built by summing four independent uniform words and subtracting their exact mean. The hit flag goes through a delay line that matches the data path, so each sample leaves the block beside its own flag. The sum is clamped at the signed limits of the output width, so it never wraps.

The table contents are computed from parameters at elaboration time. Loading measured data into them is left to the integrator.

Top module: `icdf_amp_noise`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is applied, `sample_o` reads 0 and `hit_o` reads 0 after the next rising edge.
- R2: The latency from input to output is exactly 3 clock edges. `hit_o` equals `hit_i` from 3 edges earlier, and `sample_o` is computed from the inputs sampled at that same edge.
- R3: The top 2 bits of `rnd_i` select segment s (0..3), and the low 6 bits form the index i within that segment.
- R4: With a hit, the amplitude term is 64*(2^s - 1) + i*2^s. This curve is monotone over all 256 words and runs from 0 to 952.
- R5: Without a hit, the amplitude term is 0 and the noise term still appears on `sample_o`.
- R6: `noise_i` carries four 8-bit unsigned words, with word k at bits [8k+7:8k]. The noise term is their sum minus 510, which spans -510..+510.
- R7: `sample_o` is amplitude plus noise, clamped to the 11-bit signed range -1024..1023. It never wraps.
- R8: A new sample is accepted on every clock edge, so back-to-back inputs come out on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 1 | Hit present in this sample |
| rnd_i | input | 8 | Uniform word used for the amplitude lookup |
| noise_i | input | 32 | Four packed uniform words used for noise |
| sample_o | output | 11 | Signed amplitude-plus-noise sample |
| hit_o | output | 1 | Hit flag delayed to align with `sample_o` |

## Verification
The checker assumes that `hit_i` stays low while reset is applied, so the aligned flag has a defined history. The bench drives it low throughout every reset phase. The bound checks rely on the amplitude term never being negative and on the noise term being confined to ±510. Every noise and random word the bench applies is an unsigned byte, so the stimulus stays inside those limits while still reaching both noise extremes and the clamp at the upper limit.

// File: rtl/icdf_pkg.sv
package icdf_pkg;

   // Entry idx of segment seg: segment s starts where segment s-1 ended
   // and climbs with slope 2^s, giving a monotone piecewise-linear curve.
   function automatic int seg_entry(input int seg, input int idx, input int depth);
      return depth * ((1 << seg) - 1) + idx * (1 << seg);
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/icdf_seg_rom.sv
module icdf_seg_rom #(
   parameter int SEG   = 0,
   parameter int IDX_W = 6,
   parameter int AMP_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx_i,
   output logic [AMP_W-1:0] data_q
);
   localparam int DEPTH = 1 << IDX_W;

   logic [AMP_W-1:0] rom [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_fill
      assign rom[g] = AMP_W'(icdf_pkg::seg_entry(SEG, g, DEPTH));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) data_q <= '0;
      else        data_q <= rom[idx_i];
   end
endmodule

// File: rtl/icdf_noise_sum.sv
module icdf_noise_sum #(
   parameter int NZ_W     = 8,
   parameter int NZ_TERMS = 4,
   parameter int NOISE_W  = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NZ_TERMS*NZ_W-1:0]    words_i,
   output logic signed [NOISE_W-1:0]   noise_q
);
   localparam int NPAIR  = NZ_TERMS / 2;
   localparam int PAIR_W = NZ_W + 1;
   localparam int MEAN   = NPAIR * ((1 << NZ_W) - 1);

   if (NZ_TERMS < 2 || (NZ_TERMS % 2) != 0) begin : g_bad_terms
      $error("icdf_noise_sum: NZ_TERMS must be even and at least 2");
   end
   if (NOISE_W < NZ_W + $clog2(NZ_TERMS) + 1) begin : g_bad_width
      $error("icdf_noise_sum: NOISE_W too narrow for the noise range");
   end

   logic [PAIR_W-1:0] pair_q [NPAIR];

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      always_ff @(posedge clk) begin
         if (!rst_n) pair_q[p] <= '0;
         else        pair_q[p] <= PAIR_W'(words_i[2*p*NZ_W +: NZ_W])
                                + PAIR_W'(words_i[(2*p+1)*NZ_W +: NZ_W]);
      end
   end

   logic signed [NOISE_W-1:0] total;

   always_comb begin
      total = -NOISE_W'(MEAN);
      for (int p = 0; p < NPAIR; p++) begin
         total = total + NOISE_W'(pair_q[p]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) noise_q <= '0;
      else        noise_q <= total;
   end
endmodule

// File: rtl/icdf_sat_add.sv
module icdf_sat_add #(
   parameter int AMP_W   = 10,
   parameter int NOISE_W = 11,
   parameter int OUT_W   = 11
) (
   input  logic [AMP_W-1:0]          amp_i,
   input  logic signed [NOISE_W-1:0] noise_i,
   output logic signed [OUT_W-1:0]   sum_o
);
   localparam int SUM_W  = icdf_pkg::max_int(AMP_W + 1, NOISE_W) + 1;
   localparam int OUT_HI = (1 << (OUT_W - 1)) - 1;
   localparam int OUT_LO = -(1 << (OUT_W - 1));

   logic signed [SUM_W-1:0] raw;

   always_comb begin
      raw = SUM_W'($signed({1'b0, amp_i})) + SUM_W'(noise_i);
   end

   if (SUM_W <= OUT_W) begin : g_wide
      assign sum_o = OUT_W'(raw);
   end else begin : g_clamp
      always_comb begin
         if (raw > SUM_W'(OUT_HI))      sum_o = OUT_W'(OUT_HI);
         else if (raw < SUM_W'(OUT_LO)) sum_o = OUT_W'(OUT_LO);
         else                           sum_o = OUT_W'(raw);
      end
   end
endmodule

// File: rtl/icdf_amp_noise.sv
module icdf_amp_noise #(
   parameter int RND_W     = 8,
   parameter int SEG_SEL_W = 2,
   parameter int NZ_W      = 8,
   parameter int NZ_TERMS  = 4,
   parameter int OUT_W     = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hit_i,
   input  logic [RND_W-1:0]           rnd_i,
   input  logic [NZ_TERMS*NZ_W-1:0]   noise_i,
   output logic signed [OUT_W-1:0]    sample_o,
   output logic                       hit_o
);
   localparam int NSEG    = 1 << SEG_SEL_W;
   localparam int IDX_W   = RND_W - SEG_SEL_W;
   localparam int DEPTH   = 1 << IDX_W;
   localparam int AMP_MAX = DEPTH * ((1 << NSEG) - 1) - (1 << (NSEG - 1));
   localparam int AMP_W   = $clog2(AMP_MAX + 1);
   localparam int NOISE_W = NZ_W + $clog2(NZ_TERMS) + 2;

   if (RND_W <= SEG_SEL_W) begin : g_bad_rnd
      $error("icdf_amp_noise: RND_W must exceed SEG_SEL_W");
   end
   if (SEG_SEL_W < 1 || SEG_SEL_W > 3) begin : g_bad_seg
      $error("icdf_amp_noise: SEG_SEL_W must be 1..3");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("icdf_amp_noise: OUT_W must be at least 2");
   end

   // stage 1: segment memories read, selector and flag registered
   logic [AMP_W-1:0]     rom_q [NSEG];
   logic [SEG_SEL_W-1:0] seg_d1;
   logic                 hit_d1;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      icdf_seg_rom #(
         .SEG   (s),
         .IDX_W (IDX_W),
         .AMP_W (AMP_W)
      ) u_rom (
         .clk    (clk),
         .rst_n  (rst_n),
         .idx_i  (rnd_i[IDX_W-1:0]),
         .data_q (rom_q[s])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_d1 <= '0;
         hit_d1 <= 1'b0;
      end else begin
         seg_d1 <= rnd_i[RND_W-1 -: SEG_SEL_W];
         hit_d1 <= hit_i;
      end
   end

   // stage 1 and 2: noise tree
   logic signed [NOISE_W-1:0] noise_q;

   icdf_noise_sum #(
      .NZ_W     (NZ_W),
      .NZ_TERMS (NZ_TERMS),
      .NOISE_W  (NOISE_W)
   ) u_noise (
      .clk     (clk),
      .rst_n   (rst_n),
      .words_i (noise_i),
      .noise_q (noise_q)
   );

   // stage 2: amplitude gated by the aligned flag
   logic [AMP_W-1:0] amp_q;
   logic             hit_d2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         amp_q  <= '0;
         hit_d2 <= 1'b0;
      end else begin
         amp_q  <= hit_d1 ? rom_q[seg_d1] : '0;
         hit_d2 <= hit_d1;
      end
   end

   // stage 3: clamped sum
   logic signed [OUT_W-1:0] sum_c;

   icdf_sat_add #(
      .AMP_W   (AMP_W),
      .NOISE_W (NOISE_W),
      .OUT_W   (OUT_W)
   ) u_add (
      .amp_i   (amp_q),
      .noise_i (noise_q),
      .sum_o   (sum_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample_o <= '0;
         hit_o    <= 1'b0;
      end else begin
         sample_o <= sum_c;
         hit_o    <= hit_d2;
      end
   end
endmodule

// File: rtl/icdf_amp_noise_chk.sv
module icdf_amp_noise_chk #(
   parameter int OUT_W     = 11,
   parameter int NOISE_MAX = 510
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    hit_i,
   input logic signed [OUT_W-1:0] sample_o,
   input logic                    hit_o
);
   logic       was_rst;
   logic [1:0] live_cnt;

   always_ff @(posedge clk) begin
      was_rst <= !rst_n;
      if (!rst_n)               live_cnt <= '0;
      else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
   end

   // R1
   always_ff @(posedge clk) begin
      if (was_rst == 1'b1 && rst_n) begin
         reset_clear_chk: assert (sample_o == '0 && hit_o == 1'b0)
            else $error("outputs not cleared by reset");
      end
   end

   // R2
   hit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cnt == 2'd3) |-> (hit_o == $past(hit_i, 3)));

   // R5
   idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> (sample_o >= -NOISE_MAX && sample_o <= NOISE_MAX));

   // R7
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (sample_o >= -NOISE_MAX));
endmodule

bind icdf_amp_noise icdf_amp_noise_chk #(
   .OUT_W     (OUT_W),
   .NOISE_MAX ((NZ_TERMS / 2) * ((1 << NZ_W) - 1))
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hit_i    (hit_i),
   .sample_o (sample_o),
   .hit_o    (hit_o)
);

// File: tb/icdf_amp_noise_test.sv
`timescale 1ns/1ps
module icdf_amp_noise_test;
   localparam int NV = 9;

   // {hit, rnd, n3, n2, n1, n0}
   localparam logic [40:0] VEC [NV] = '{
      {1'b1, 8'h00, 32'h7F7F7F7F},
      {1'b1, 8'h3F, 32'h80808080},
      {1'b1, 8'h40, 32'h00000000},
      {1'b1, 8'hBF, 32'hFFFFFFFF},
      {1'b1, 8'hFF, 32'hFFFFFFFF},
      {1'b0, 8'hFF, 32'hFFFFFFFF},
      {1'b0, 8'h80, 32'h00000000},
      {1'b1, 8'hC5, 32'h281E140A},
      {1'b1, 8'hFF, 32'h92919191}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hit_i = 1'b0;
   logic [7:0]  rnd_i = '0;
   logic [31:0] noise_i = '0;
   logic signed [10:0] sample_o;
   logic        hit_o;

   int pass_cnt = 0;
   int total_cnt = 0;

   always #2.5 clk = ~clk;

   icdf_amp_noise uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_i    (hit_i),
      .rnd_i    (rnd_i),
      .noise_i  (noise_i),
      .sample_o (sample_o),
      .hit_o    (hit_o)
   );

   function automatic int model(input logic [40:0] v);
      int s, i, amp, nz, r;
      s   = int'(v[39:38]);
      i   = int'(v[37:32]);
      amp = v[40] ? 64 * ((1 << s) - 1) + i * (1 << s) : 0;
      nz  = int'(v[7:0]) + int'(v[15:8]) + int'(v[23:16]) + int'(v[31:24]) - 510;
      r   = amp + nz;
      if (r > 1023)  r = 1023;
      if (r < -1024) r = -1024;
      return r;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total_cnt++;
      if (act == exp) pass_cnt++;
      else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
   endtask

   task automatic drive(input logic [40:0] v);
      hit_i   = v[40];
      rnd_i   = v[39:32];
      noise_i = v[31:0];
   endtask

   initial begin
      #200us;
      total_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", pass_cnt, total_cnt);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 sample in reset", int'(sample_o), 0);
      chk("R1 hit_o in reset", int'(hit_o), 0);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6 R7 R8: streamed back to back, one vector per cycle
      for (int k = 0; k < NV + 3; k++) begin
         @(negedge clk);
         if (k >= 3) begin
            if (k - 3 == 4 || k - 3 == 8)
               chk("R7 clamp", int'(sample_o), model(VEC[k-3]));
            else if (!VEC[k-3][40])
               chk("R5 noise only", int'(sample_o), model(VEC[k-3]));
            else
               chk("R3 R4 R6 R8 sample", int'(sample_o), model(VEC[k-3]));
            chk("R2 hit delay", int'(hit_o), int'(VEC[k-3][40]));
         end
         if (k < NV) drive(VEC[k]);
         else        drive('0);
      end

      // R1 reset in mid-stream clears the pipeline
      @(negedge clk);
      drive({1'b1, 8'hFF, 32'hFFFFFFFF});
      repeat (2) @(negedge clk);
      hit_i = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 sample after mid reset", int'(sample_o), 0);
      chk("R1 hit_o after mid reset", int'(hit_o), 0);
      rst_n = 1'b1;
      drive('0);
      repeat (3) @(negedge clk);
      chk("R5 idle zero-input noise", int'(sample_o), -510);

      $display("%0d/%0d checks passed", pass_cnt, total_cnt);
      $finish;
   end
endmodule